// File: doc/BRIEF.md
# Interrupt Request Collector with Hold-Off and Service Timeout

This block gathers single-cycle event flags from a set of sources into a pending-interrupt register. It drives an active-low interrupt request toward a host processor. The host fetches the pending bits with a one-cycle read strobe, and that read clears every bit at once. Each read also starts a hold-off window, during which the request line stays released. An edge-sensitive host input therefore always sees a fresh falling edge when work is still waiting.

A per-source enable mask decides which sources may raise pending bits. A status vector records every raw condition whatever the mask says. If a pending bit stays unread for too long, the block raises a system-reset request.

In Normal mode, the sources chosen by a parameter mask are rate limited: each may set its bit at most once per watchdog period. A one-cycle period-start pulse re-arms them. One source is the over-temperature monitor. It only reports, and it never shuts anything down.

Top module: `irq_hub`

## Requirements
- R1: `irq_n_o` is 0 exactly when at least one pending bit is set and no hold-off window is running; otherwise it is 1.
- R2: `rd_data_o` shows the pending register. A cycle with `rd_i`=1 clears every pending bit at the next clock edge.
- R3: While `rst_n` is 0, the pending bits, status bits and both timers are cleared, `irq_n_o` is 1 and `sys_rst_req_o` is 0.
- R4: For the HOLD_CYC cycles that follow the edge closing a read cycle, `irq_n_o` is 1, even if new events are pending. A read inside the window restarts it.
- R5: When the hold-off window ends, `irq_n_o` goes to 0 if bits are pending; otherwise it stays 1.
- R6: If pending bits stay unread for TMO_CYC consecutive edges, `sys_rst_req_o` becomes 1 at that edge. It stays 1 until a read cycle or reset, and a read drops it at the following edge.
- R7: With `normal_mode_i`=1, a source whose bit is 1 in RATE_MASK can set its pending bit only once per watchdog period. Later events from it are dropped. A `wd_start_i` pulse opens a new period, and an event in that same cycle is accepted. With `normal_mode_i`=0 no source is limited.
- R8: An event arriving in a read cycle is set into the pending register after the clear, so it is not lost.
- R9: A source whose `en_i` bit is 0 does not set its pending bit. `status_o` holds each source's `evt_i` value from the previous cycle, regardless of `en_i`.
- R10: An over-temperature event (source index TEMP_IDX, default 5) affects only its own status bit and, if enabled, its own pending bit. It leaves the other pending bits alone and raises no reset request by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | System reset, active low, asynchronous |
| evt_i | input | NUM_SRC | Event flags, one per source, sampled every cycle |
| en_i | input | NUM_SRC | Per-source interrupt enable mask |
| normal_mode_i | input | 1 | Normal mode; enables rate limiting |
| wd_start_i | input | 1 | One-cycle pulse at the start of each watchdog period |
| rd_i | input | 1 | Read strobe for the pending register |
| rd_data_o | output | NUM_SRC | Pending interrupt bits |
| status_o | output | NUM_SRC | Raw condition status, one cycle late |
| irq_n_o | output | 1 | Interrupt request, active low |
| sys_rst_req_o | output | 1 | System reset request after a service timeout |

## Verification
A vector table drives mixes of single events and multi-source events, with enables fully open, partly masked and fully closed, some of them arriving together with a read. This separates clean accumulation from read-clear, from the set-after-clear ordering, and from mask blocking. Directed runs then place an event inside the hold-off window and omit it in a second window, so that a release held by the timer can be told apart from a release caused by an empty register. The timeout is probed one cycle before and at its limit. Rate limiting is tried on a limited source and a free source, in both modes and across a period start.

// File: rtl/irq_hub_pkg.sv
`timescale 1ns/1ps
package irq_hub_pkg;
    // default geometry of the collector
    localparam int unsigned DEF_NUM_SRC  = 6;
    localparam int unsigned DEF_HOLD_CYC = 16;
    localparam int unsigned DEF_TMO_CYC  = 1000;
    localparam int unsigned DEF_TEMP_IDX = 5;

    // width of a counter that must hold values 0..max_val
    function automatic int unsigned cnt_width(input int unsigned max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction
endpackage

// File: rtl/irq_rate_gate.sv
`timescale 1ns/1ps
module irq_rate_gate #(
    parameter int unsigned       NUM_SRC   = 6,
    parameter logic [NUM_SRC-1:0] RATE_MASK = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic [NUM_SRC-1:0] en_i,
    input  logic               normal_mode_i,
    input  logic               period_start_i,
    output logic [NUM_SRC-1:0] accept_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] used;
    } gate_st_t;

    gate_st_t st_d, st_q;
    logic [NUM_SRC-1:0] blocked;
    logic [NUM_SRC-1:0] marks;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        if (RATE_MASK[g]) begin : g_lim
            // a limited source is closed once it has fired in this period
            assign blocked[g] = normal_mode_i & st_q.used[g] & ~period_start_i;
            assign marks[g]   = normal_mode_i;
        end else begin : g_free
            assign blocked[g] = 1'b0;
            assign marks[g]   = 1'b0;
        end
    end

    always_comb begin
        accept_o    = evt_i & en_i & ~blocked;
        st_d        = st_q;
        st_d.used   = (period_start_i ? '0 : st_q.used) | (accept_o & marks);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // a limited source that already fired must not pass again in Normal mode
    AST_RATE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (normal_mode_i && !period_start_i) |->
            ((accept_o & RATE_MASK & st_q.used) == '0)); // R7
endmodule

// File: rtl/irq_holdoff_timer.sv
`timescale 1ns/1ps
module irq_holdoff_timer #(
    parameter int unsigned HOLD_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic active_o
);
    localparam int unsigned CW = irq_hub_pkg::cnt_width(HOLD_CYC);
    localparam logic [CW-1:0] LOAD = CW'(HOLD_CYC);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } hold_st_t;

    hold_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start_i)              st_d.cnt = LOAD;
        else if (st_q.cnt != '0)  st_d.cnt = st_q.cnt - 1'b1;
        active_o = (st_q.cnt != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // a start always opens the window on the next cycle
    AST_HOLD_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> active_o); // R4
endmodule

// File: rtl/irq_service_timer.sv
`timescale 1ns/1ps
module irq_service_timer #(
    parameter int unsigned TMO_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic pending_i,
    output logic expire_o
);
    localparam int unsigned CW = irq_hub_pkg::cnt_width(TMO_CYC);
    localparam logic [CW-1:0] LIMIT = CW'(TMO_CYC);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmo_st_t;

    tmo_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i || !pending_i) st_d.cnt = '0;
        else if (st_q.cnt != LIMIT) st_d.cnt = st_q.cnt + 1'b1;
        expire_o = (st_q.cnt == LIMIT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // a clear always withdraws the request on the next cycle
    AST_CLEAR_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> !expire_o); // R6
endmodule

// File: rtl/irq_hub.sv
`timescale 1ns/1ps
module irq_hub #(
    parameter int unsigned        NUM_SRC   = irq_hub_pkg::DEF_NUM_SRC,
    parameter int unsigned        HOLD_CYC  = irq_hub_pkg::DEF_HOLD_CYC,
    parameter int unsigned        TMO_CYC   = irq_hub_pkg::DEF_TMO_CYC,
    parameter int unsigned        TEMP_IDX  = irq_hub_pkg::DEF_TEMP_IDX,
    parameter logic [NUM_SRC-1:0] RATE_MASK = NUM_SRC'(3)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic [NUM_SRC-1:0] en_i,
    input  logic               normal_mode_i,
    input  logic               wd_start_i,
    input  logic               rd_i,
    output logic [NUM_SRC-1:0] rd_data_o,
    output logic [NUM_SRC-1:0] status_o,
    output logic               irq_n_o,
    output logic               sys_rst_req_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] pend;
        logic [NUM_SRC-1:0] stat;
    } hub_st_t;

    hub_st_t st_d, st_q;
    logic [NUM_SRC-1:0] accept;
    logic               hold_active;
    logic               any_pend;

    irq_rate_gate #(
        .NUM_SRC   (NUM_SRC),
        .RATE_MASK (RATE_MASK)
    ) u_gate (
        .clk            (clk),
        .rst_n          (rst_n),
        .evt_i          (evt_i),
        .en_i           (en_i),
        .normal_mode_i  (normal_mode_i),
        .period_start_i (wd_start_i),
        .accept_o       (accept)
    );

    irq_holdoff_timer #(
        .HOLD_CYC (HOLD_CYC)
    ) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (rd_i),
        .active_o (hold_active)
    );

    irq_service_timer #(
        .TMO_CYC (TMO_CYC)
    ) u_tmo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (rd_i),
        .pending_i (any_pend),
        .expire_o  (sys_rst_req_o)
    );

    always_comb begin
        st_d      = st_q;
        // clear first, then merge the accepted events of this cycle
        st_d.pend = (rd_i ? '0 : st_q.pend) | accept;
        st_d.stat = evt_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign any_pend  = |st_q.pend;
    assign rd_data_o = st_q.pend;
    assign status_o  = st_q.stat;
    assign irq_n_o   = ~(any_pend & ~hold_active);

    // the request line is never low with an empty register
    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n_o |-> (rd_data_o != '0)); // R1
    // a read with no new events leaves the register empty
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && evt_i == '0) |=> (rd_data_o == '0)); // R2
    // the line is released right after a read, whatever arrives
    AST_HOLD_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i |=> irq_n_o); // R4
    // a reset request only exists while something is pending
    AST_REQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req_o |-> (rd_data_o != '0)); // R6
    // right after a read only enabled sources can be pending
    AST_MASK_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i |=> ((rd_data_o & ~$past(en_i)) == '0)); // R9
    // the over-temperature index must name a real source
    initial AST_TEMP_IDX_OK: assert (TEMP_IDX < NUM_SRC); // R10
endmodule

// File: tb/irq_hub_tb.sv
`timescale 1ns/1ps
module irq_hub_tb;
    localparam int unsigned N    = 6;
    localparam int unsigned HOLD = 4;
    localparam int unsigned TMO  = 20;
    localparam int unsigned TIDX = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] evt = '0, en = '0;
    logic         normal = 1'b0, wds = 1'b0, rd = 1'b0;
    logic [N-1:0] rd_data, status;
    logic         irq_n, sys_rst_req;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    irq_hub #(
        .NUM_SRC (N), .HOLD_CYC (HOLD), .TMO_CYC (TMO),
        .TEMP_IDX (TIDX), .RATE_MASK (6'b000011)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .evt_i (evt), .en_i (en),
        .normal_mode_i (normal), .wd_start_i (wds), .rd_i (rd),
        .rd_data_o (rd_data), .status_o (status),
        .irq_n_o (irq_n), .sys_rst_req_o (sys_rst_req)
    );

    // row: evt[6] en[6] rd[1] exp_pend[6]
    localparam int ROWS = 8;
    localparam logic [18:0] VEC [ROWS] = '{
        {6'h01, 6'h3F, 1'b0, 6'h01},  // R2 single event
        {6'h04, 6'h3F, 1'b0, 6'h05},  // R2 accumulate
        {6'h00, 6'h3F, 1'b1, 6'h00},  // R2 read clears
        {6'h10, 6'h3F, 1'b1, 6'h10},  // R8 event in read cycle kept
        {6'h22, 6'h0F, 1'b0, 6'h12},  // R9 partial mask
        {6'h08, 6'h3F, 1'b1, 6'h08},  // R8 clear then set
        {6'h00, 6'h3F, 1'b1, 6'h00},  // R2 read empties
        {6'h3F, 6'h00, 1'b0, 6'h00}   // R9 all masked
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        evt = '0; rd = 1'b0; wds = 1'b0;
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic do_read();
        evt = '0; rd = 1'b1; step(); rd = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R3 reset state
        repeat (2) @(negedge clk);
        chk("R3 pend in reset", 32'(rd_data), 0);
        chk("R3 irq_n in reset", 32'(irq_n), 1);
        chk("R3 req in reset", 32'(sys_rst_req), 0);
        chk("R3 status in reset", 32'(status), 0);
        rst_n = 1'b1;
        step();

        for (int r = 0; r < ROWS; r++) begin
            evt = VEC[r][18:13]; en = VEC[r][12:7]; rd = VEC[r][6];
            step();
            chk($sformatf("R2/R8/R9 row %0d pend", r), 32'(rd_data), 32'(VEC[r][5:0]));
            chk($sformatf("R9 row %0d status", r), 32'(status), 32'(VEC[r][18:13]));
        end
        idle(HOLD + 1);

        // R1 / R4 / R5 hold-off
        en = '1;
        evt = 6'h01; rd = 1'b0; step(); evt = '0;
        chk("R1 irq low with pending", 32'(irq_n), 0);
        do_read();
        chk("R4 released after read", 32'(irq_n), 1);
        evt = 6'h02; step(); evt = '0;
        chk("R4 pending during hold", 32'(rd_data), 32'h02);
        chk("R4 held high (1)", 32'(irq_n), 1);
        step(); chk("R4 held high (2)", 32'(irq_n), 1);
        step(); chk("R4 held high (3)", 32'(irq_n), 1);
        step(); chk("R5 low after hold", 32'(irq_n), 0);
        do_read();
        idle(HOLD);
        chk("R5 stays high when empty", 32'(irq_n), 1);

        // R6 service timeout
        evt = 6'h04; step(); evt = '0;
        for (int i = 0; i < int'(TMO) - 1; i++) step();
        chk("R6 no request before limit", 32'(sys_rst_req), 0);
        step();
        chk("R6 request at limit", 32'(sys_rst_req), 1);
        step();
        chk("R6 request sticky", 32'(sys_rst_req), 1);
        do_read();
        chk("R6 read drops request", 32'(sys_rst_req), 0);
        idle(HOLD);

        // R7 rate limiting
        normal = 1'b1;
        evt = 6'h01; step(); evt = '0;
        chk("R7 first event accepted", 32'(rd_data), 32'h01);
        do_read();
        evt = 6'h01; step(); evt = '0;
        chk("R7 second event dropped", 32'(rd_data), 32'h00);
        evt = 6'h01; wds = 1'b1; step(); evt = '0; wds = 1'b0;
        chk("R7 accepted at period start", 32'(rd_data), 32'h01);
        do_read();
        evt = 6'h20; step(); evt = '0;
        do_read();
        evt = 6'h20; step(); evt = '0;
        chk("R7 free source repeats", 32'(rd_data), 32'h20);
        do_read();
        normal = 1'b0;
        evt = 6'h01; step(); evt = '0;
        chk("R7 no limit outside Normal", 32'(rd_data), 32'h01);
        do_read();
        idle(HOLD);

        // R10 over-temperature
        en = 6'h1F;
        evt = 6'h20; step(); evt = '0;
        chk("R10 status recorded", 32'(status), 32'h20);
        chk("R10 masked: no pending", 32'(rd_data), 32'h00);
        chk("R10 masked: irq high", 32'(irq_n), 1);
        en = '1;
        evt = 6'h01; step();
        evt = 6'h20; step(); evt = '0;
        chk("R10 only own bit added", 32'(rd_data), 32'h21);
        chk("R10 no reset request", 32'(sys_rst_req), 0);

        // R3 reset while pending
        rst_n = 1'b0;
        @(negedge clk);
        chk("R3 reset clears pend", 32'(rd_data), 0);
        chk("R3 reset irq_n high", 32'(irq_n), 1);
        chk("R3 reset status", 32'(status), 0);
        rst_n = 1'b1;
        step();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule